// File: doc/BRIEF.md
# Multi-Mode 16-bit Reload Timer

This block is one timer channel built around a single 16-bit down counter. The counter can be clocked in three ways. It can count ticks of the peripheral clock after a power-of-two prescaler. It can count rising edges on an external input, which makes it an event counter. It can also count prescaled ticks only while the external input is high, which measures the width of a pulse.

When the counter passes zero it reloads itself from a reload register, so the timer runs periodically. Each time it reloads, it emits a one-cycle underflow pulse, sets a sticky interrupt flag and toggles a serial clock output. Software writes a configuration word (the mode and the division code), writes the reload value, presets the counter, starts and stops it with a run level, and reads the live count and the captured pulse width back.

Top module: `reload_timer16`

## Requirements
- R1: After reset the count, the capture value, the capture-done flag, the underflow pulse, the interrupt flag and the serial clock output are all 0. The configured mode, the division code and the reload value are also 0.
- R2: The mode field written with `cfg_we_i` selects how the counter is clocked. 0 means prescaled internal clock, 1 means external edge counting, 2 means pulse width measurement and 3 is reserved.
- R3: In internal mode with division code d (0 to 14), the counter steps once every 2^d clock cycles. The first step comes on the 2^d-th rising edge after `run_i` goes high.
- R4: A count step taken while the count is 0 loads the reload value. In the cycle the reload value appears, `underflow_o` is high for exactly one cycle. `irq_o` is set and stays set until `irq_clr_i` is applied; if a new underflow arrives in the same cycle as the clear, the flag stays set.
- R5: `sclk_o` toggles on every underflow, so its period is two underflow periods.
- R6: `preset_i` loads the reload value into the counter on the next edge. It takes priority over a count step.
- R7: While `run_i` is low the count holds, and the prescaler restarts from zero.
- R8: With mode code 3 or division code 15 the count holds even while `run_i` is high.
- R9: In external mode, `ext_i` passes through a two-flop synchronizer. Each rising edge removes exactly one count, however long the input stays high. The count changes on the third rising clock edge after `ext_i` rises.
- R10: In pulse width mode, the counter steps on prescaled ticks while the synchronized input is high, and holds while it is low. On the falling edge of the synchronized input, the count is copied to `capture_o` and `cap_done_o` is set. `cap_clr_i` clears `cap_done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Write strobe for the mode and division fields |
| mode_i | input | 2 | Mode code to write |
| div_i | input | 4 | Division code to write |
| reload_we_i | input | 1 | Write strobe for the reload value |
| reload_i | input | 16 | Reload value to write |
| preset_i | input | 1 | Copy the reload value into the counter |
| run_i | input | 1 | Counting enable level |
| ext_i | input | 1 | External event or pulse input (asynchronous) |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| cap_clr_i | input | 1 | Clears the capture-done flag |
| count_o | output | 16 | Live counter value |
| capture_o | output | 16 | Count captured at the end of a pulse |
| cap_done_o | output | 1 | A capture has taken place |
| underflow_o | output | 1 | One-cycle pulse on reload after zero |
| irq_o | output | 1 | Sticky underflow interrupt flag |
| sclk_o | output | 1 | Serial clock, toggled on each underflow |

## Verification
Internal mode is run at division code 0 and at code 2. The first run shows that a step happens on every edge and that the wrap lands exactly one tick after zero. The second shows that the prescaler delays the first step by four edges and then spaces the steps by four. The external mode uses pulses that are held high for several cycles, which tells edge counting apart from level counting. A single pulse then checks the three-edge synchronizer latency. The pulse width mode uses a known 10-cycle high level, preceded by a low interval that must not count, so both the gating and the capture value are tested. The reserved codes, a low run level and a preset are each checked against a count that must not move, or that must jump to the reload value.

// File: rtl/reload_timer16.sv
module reload_timer16 #(
  parameter int CW = 16,
  parameter int DW = 4,
  localparam int PW = (1 << DW) - 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we_i,
  input  logic [1:0]    mode_i,
  input  logic [DW-1:0] div_i,
  input  logic          reload_we_i,
  input  logic [CW-1:0] reload_i,
  input  logic          preset_i,
  input  logic          run_i,
  input  logic          ext_i,
  input  logic          irq_clr_i,
  input  logic          cap_clr_i,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] capture_o,
  output logic          cap_done_o,
  output logic          underflow_o,
  output logic          irq_o,
  output logic          sclk_o
);
  localparam logic [1:0] M_INT = 2'd0, M_EXT = 2'd1, M_PW = 2'd2;

  logic [1:0]    mode_q;
  logic [DW-1:0] div_q;
  logic [CW-1:0] reload_q, cnt_q;
  logic [PW-1:0] pre_q, mask;
  logic          s1_q, s2_q, s3_q;
  logic          cfg_ok, tick_int, rise, fall, tick, wrap;

  assign mask     = ~({PW{1'b1}} << div_q);
  assign tick_int = (pre_q & mask) == mask;
  assign cfg_ok   = (mode_q != 2'd3) && (div_q != {DW{1'b1}});
  assign rise     = s2_q & ~s3_q;
  assign fall     = ~s2_q & s3_q;

  always_comb begin
    case (mode_q)
      M_INT:   tick = tick_int;
      M_EXT:   tick = rise;
      M_PW:    tick = tick_int & s2_q;
      default: tick = 1'b0;
    endcase
    tick = tick & run_i & cfg_ok & ~preset_i;
  end

  assign wrap    = tick && (cnt_q == '0);
  assign count_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; div_q <= '0; reload_q <= '0;
    end else begin
      if (cfg_we_i) begin
        mode_q <= mode_i;
        div_q  <= div_i;
      end
      if (reload_we_i) reload_q <= reload_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {s1_q, s2_q, s3_q} <= '0;
    else        {s1_q, s2_q, s3_q} <= {ext_i, s1_q, s2_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (!run_i) pre_q <= '0;
    else             pre_q <= pre_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; underflow_o <= 1'b0; irq_o <= 1'b0; sclk_o <= 1'b0;
    end else begin
      underflow_o <= wrap;
      if (preset_i)  cnt_q <= reload_q;
      else if (wrap) cnt_q <= reload_q;
      else if (tick) cnt_q <= cnt_q - CW'(1);
      if (wrap) begin
        irq_o  <= 1'b1;
        sclk_o <= ~sclk_o;
      end else if (irq_clr_i) irq_o <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capture_o <= '0; cap_done_o <= 1'b0;
    end else if (mode_q == M_PW && fall) begin
      capture_o  <= cnt_q;
      cap_done_o <= 1'b1;
    end else if (cap_clr_i) cap_done_o <= 1'b0;
  end

  p_uf_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |-> (count_o == $past(reload_q)) && irq_o);
  p_uf_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o && (reload_q != '0) |=> !underflow_o);
  p_sclk_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |-> sclk_o != $past(sclk_o));
  p_sclk_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !underflow_o |-> $stable(sclk_o));
  p_preset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    preset_i |=> count_o == $past(reload_q));
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i || !cfg_ok) && !preset_i |=> $stable(count_o));
  p_step_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(preset_i) && !underflow_o && (count_o != $past(count_o))
      |-> count_o == $past(count_o) - CW'(1));
endmodule

// File: tb/reload_timer16_bench.sv
module reload_timer16_bench;
  localparam int TCLK = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, reload_we = 0, preset = 0, run = 0, ext = 0, irq_clr = 0, cap_clr = 0;
  logic [1:0] mode = 0;
  logic [3:0] div = 0;
  logic [15:0] reload = 0;
  logic [15:0] count, capture;
  logic cap_done, underflow, irq, sclk;
  int errors = 0, checks = 0;

  always #(TCLK/2) clk = ~clk;

  reload_timer16 u_reload_timer16 (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .mode_i(mode), .div_i(div),
    .reload_we_i(reload_we), .reload_i(reload), .preset_i(preset), .run_i(run),
    .ext_i(ext), .irq_clr_i(irq_clr), .cap_clr_i(cap_clr), .count_o(count),
    .capture_o(capture), .cap_done_o(cap_done), .underflow_o(underflow),
    .irq_o(irq), .sclk_o(sclk));

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(logic [1:0] m, logic [3:0] d);
    mode = m; div = d; cfg_we = 1; cyc(1); cfg_we = 0;
  endtask

  task automatic load(int v);
    reload = 16'(v); reload_we = 1; cyc(1); reload_we = 0;
    preset = 1; cyc(1); preset = 0;
  endtask

  task automatic t_reset;
    chk("R1 count", count, 0); chk("R1 capture", capture, 0);
    chk("R1 cap_done", cap_done, 0); chk("R1 underflow", underflow, 0);
    chk("R1 irq", irq, 0); chk("R1 sclk", sclk, 0);
    run = 1; preset = 1; cyc(1); preset = 0; run = 0;
    chk("R1 reload zero", count, 0);
  endtask

  task automatic t_internal;
    set_cfg(2'd0, 4'd0);
    load(3);
    chk("R6 preset", count, 3);
    run = 1;
    cyc(1); chk("R2 step1", count, 2);
    cyc(2); chk("R2 step3", count, 0);
    chk("R4 no early uf", underflow, 0);
    cyc(1); chk("R4 wrap", count, 3); chk("R4 uf pulse", underflow, 1);
    chk("R4 irq set", irq, 1); chk("R5 sclk 1", sclk, 1);
    cyc(1); chk("R4 uf one cycle", underflow, 0);
    cyc(3); chk("R5 sclk 0", sclk, 0);
    run = 0;
    irq_clr = 1; cyc(1); irq_clr = 0;
    chk("R4 irq clr", irq, 0);
  endtask

  task automatic t_prescale;
    set_cfg(2'd0, 4'd2);
    load(5);
    run = 1;
    cyc(3); chk("R3 before first tick", count, 5);
    cyc(1); chk("R3 first tick", count, 4);
    cyc(3); chk("R3 between ticks", count, 4);
    cyc(1); chk("R3 second tick", count, 3);
  endtask

  task automatic t_run_stop;
    run = 0; cyc(10); chk("R7 hold", count, 3);
    preset = 1; run = 1; cyc(1); preset = 0;
    chk("R6 preset over step", count, 5);
    run = 0;
  endtask

  task automatic t_reserved;
    set_cfg(2'd3, 4'd0);
    load(7);
    run = 1; cyc(20); chk("R8 mode 3 hold", count, 7);
    run = 0;
    set_cfg(2'd0, 4'd15);
    run = 1; cyc(20); chk("R8 div 15 hold", count, 7);
    run = 0;
  endtask

  task automatic t_event;
    set_cfg(2'd1, 4'd0);
    load(100);
    run = 1;
    for (int i = 0; i < 4; i++) begin
      ext = 1; cyc(5); ext = 0; cyc(3);
    end
    cyc(3); chk("R9 four edges", count, 96);
    ext = 1; cyc(2); chk("R9 latency two", count, 96);
    cyc(1); chk("R9 latency three", count, 95);
    cyc(6); chk("R9 one per edge", count, 95);
    ext = 0; cyc(3); run = 0;
  endtask

  task automatic t_pulse;
    set_cfg(2'd2, 4'd0);
    load(100);
    run = 1;
    cyc(5); chk("R10 low holds", count, 100);
    ext = 1; cyc(10); ext = 0; cyc(5);
    chk("R10 width count", count, 90);
    chk("R10 capture", capture, 90);
    chk("R10 cap_done", cap_done, 1);
    run = 0;
    cap_clr = 1; cyc(1); cap_clr = 0;
    chk("R10 cap clr", cap_done, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    t_reset();
    t_internal();
    t_prescale();
    t_run_stop();
    t_reserved();
    t_event();
    t_pulse();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule